// File: doc/BRIEF.md
# Chunked Block-Storage DMA Sequencer

This block sits between a descriptor-driven DMA channel and a block-storage port. The drive side arms a transfer with a start pulse. With that pulse it gives the medium kind (hard disk or optical), the command, the starting sector or logical block, and the length. The start pulse loads the count of bytes still to move and clears the running byte index. From then on the DMA channel offers one memory chunk at a time, each an address and a byte length. For every chunk that carries data, the block issues exactly one storage operation, aimed at a byte offset derived from the medium kind, the base block and the running index. It then shrinks the remaining count and grows the index by the chunk length.

Each chunk the block handles ends with a one-cycle step-end strobe back to the channel, whatever the reason for the end: data moved, an empty chunk, an error, or completion. A chunk that arrives before any transfer is armed is held untouched until a start arrives. The transfer is over when the remaining count has fallen to zero or below. A disk then reports ready status and an interrupt pulse; an optical drive reports a command-done pulse. Optical transfers without a block address copy from a local buffer straight to memory. A flush request is acknowledged only when no storage operation is outstanding.

Top module: `dma_chunk_seq`

## Requirements
- R1: A start pulse, taken when no storage operation is outstanding, sets the byte index to 0 and loads the remaining count (sector count × 512 for disk, packet byte count for optical). It raises active_o and sets status_o to 0x80 on the next cycle. A start while a storage operation is outstanding is ignored.
- R2: A chunk offered while active_o is low raises parked_o, issues no storage request and no step-end strobe, and is handled once a later start has armed the transfer.
- R3: The transfer completes when a chunk arrives with the remaining count ≤ 0, or when a storage operation finishes without error and leaves the count ≤ 0. On completion status_o becomes 0x50, active_o falls, and a one-cycle pulse appears on disk_irq_o (disk) or cmd_ok_o (optical), in the same cycle as dma_end_o.
- R4: A zero-length chunk with a positive remaining count ends the step with no storage request and leaves the index and the remaining count unchanged.
- R5: The storage offset is (sector << 9) + index for disk and (block << 11) + index for optical.
- R6: A data chunk issues one sto_req_o pulse that carries the chunk address and the chunk length. The remaining count then falls by the chunk length and the index rises by it.
- R7: sto_op_o encodes 0 read, 1 write, 2 trim, 3 buffer copy. The disk command codes 0, 1 and 2 map to ops 0, 1 and 2. Optical block transfers always use op 0.
- R8: A disk data chunk under command code 3 issues no storage request. It sets fatal_o, which holds until the next start, clears active_o and ends the step.
- R9: A storage completion with sto_err_i high pulses io_err_o, sets status_o to 0x51, clears active_o and ends the step.
- R10: An optical transfer whose block field is all ones issues op 3 at offset 0 with length min(remaining, chunk length). When it finishes it pulses cmd_ok_o, sets status_o to 0x50 and clears active_o.
- R11: Each handled chunk gives exactly one dma_end_o pulse. When a storage request was issued, the pulse comes only after sto_done_i.
- R12: flush_ack_o pulses for one cycle after flush_i, never while a storage operation is outstanding, and on the next cycle when none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Arm a transfer |
| optical_i | input | 1 | Medium kind at start: 1 optical, 0 disk |
| cmd_i | input | 2 | Disk command code at start |
| sector_i | input | LBA_W | Disk start sector at start |
| nsect_i | input | NSEC_W | Disk sector count at start |
| pkt_bytes_i | input | PKT_W | Optical byte count at start |
| lba_i | input | LBA_W | Optical start block; all ones selects buffer copy |
| chunk_valid_i | input | 1 | Chunk offered, held until dma_end_o |
| chunk_addr_i | input | ADDR_W | Chunk memory address |
| chunk_len_i | input | LEN_W | Chunk byte length |
| sto_done_i | input | 1 | Storage operation finished |
| sto_err_i | input | 1 | Error qualifier for sto_done_i |
| flush_i | input | 1 | Flush request |
| sto_req_o | output | 1 | Storage request pulse |
| sto_op_o | output | 2 | Storage operation code |
| sto_off_o | output | LBA_W+12 | Storage byte offset |
| sto_addr_o | output | ADDR_W | Memory address for the operation |
| sto_len_o | output | LEN_W | Byte length for the operation |
| dma_end_o | output | 1 | Step-end strobe to the channel |
| active_o | output | 1 | Transfer armed |
| parked_o | output | 1 | Chunk waiting for arming |
| cmd_ok_o | output | 1 | Optical command-done pulse |
| disk_irq_o | output | 1 | Disk interrupt pulse |
| io_err_o | output | 1 | Storage error pulse |
| fatal_o | output | 1 | Illegal disk command seen |
| status_o | output | 8 | Drive status byte |
| flush_ack_o | output | 1 | Flush acknowledge pulse |

## Verification
A wrong remaining count shows at the ports as completion coming one chunk early or late, through disk_irq_o or cmd_ok_o. A wrong index shows at once in sto_off_o of the next request in the same transfer. A misplaced active flag makes a chunk park when it should run, or run when it should park, and this is visible within two cycles of the chunk being offered. Errors in step sequencing show as a missing or doubled dma_end_o, or as a strobe ahead of sto_done_i, and are caught in the same cycle.

// File: rtl/chunk_seq_pkg.sv
package chunk_seq_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_TRIM  = 2'd2,
        OP_COPY  = 2'd3
    } sto_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_END  = 2'd2
    } seq_state_e;

    localparam logic [7:0] STAT_BUSY = 8'h80;
    localparam logic [7:0] STAT_DONE = 8'h50;
    localparam logic [7:0] STAT_FAIL = 8'h51;

    localparam logic [1:0] CMD_BAD = 2'd3;

    localparam int SECT_SHIFT = 9;
    localparam int BLK_SHIFT  = 11;

endpackage

// File: rtl/chunk_seq_offset.sv
module chunk_seq_offset #(
    parameter int LBA_W = 24,
    parameter int OFF_W = LBA_W + 12
) (
    input  logic             optical_i,
    input  logic [LBA_W-1:0] base_i,
    input  logic [OFF_W-1:0] idx_i,
    output logic [OFF_W-1:0] off_o
);
    import chunk_seq_pkg::*;

    logic [OFF_W-1:0] base_ext;

    always_comb begin
        base_ext = OFF_W'(base_i);
        if (optical_i) begin
            off_o = (base_ext << BLK_SHIFT) + idx_i;
        end else begin
            off_o = (base_ext << SECT_SHIFT) + idx_i;
        end
    end

endmodule

// File: rtl/chunk_seq_flush.sv
module chunk_seq_flush (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic busy_i,
    output logic flush_ack_o
);

    typedef struct packed {
        logic pend;
        logic ack;
    } fl_t;

    fl_t d, q;

    always_comb begin
        d     = q;
        d.ack = 1'b0;
        if (q.pend || flush_i) begin
            if (busy_i) begin
                d.pend = 1'b1;
            end else begin
                d.pend = 1'b0;
                d.ack  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign flush_ack_o = q.ack;

    p_ack_not_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ack_o |-> !$past(busy_i));

    p_ack_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ack_o |=> !flush_ack_o || $past(flush_i));

endmodule

// File: rtl/chunk_seq_ctrl.sv
module chunk_seq_ctrl #(
    parameter int LBA_W  = 24,
    parameter int NSEC_W = 8,
    parameter int PKT_W  = 16,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = LBA_W + 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              optical_i,
    input  logic [1:0]        cmd_i,
    input  logic [LBA_W-1:0]  sector_i,
    input  logic [NSEC_W-1:0] nsect_i,
    input  logic [PKT_W-1:0]  pkt_bytes_i,
    input  logic [LBA_W-1:0]  lba_i,
    input  logic              chunk_valid_i,
    input  logic [ADDR_W-1:0] chunk_addr_i,
    input  logic [LEN_W-1:0]  chunk_len_i,
    input  logic              sto_done_i,
    input  logic              sto_err_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic              optical_o,
    output logic [LBA_W-1:0]  base_o,
    output logic [OFF_W-1:0]  idx_o,
    output logic              busy_o,
    output logic              sto_req_o,
    output logic [1:0]        sto_op_o,
    output logic [OFF_W-1:0]  sto_off_o,
    output logic [ADDR_W-1:0] sto_addr_o,
    output logic [LEN_W-1:0]  sto_len_o,
    output logic              dma_end_o,
    output logic              active_o,
    output logic              parked_o,
    output logic              cmd_ok_o,
    output logic              disk_irq_o,
    output logic              io_err_o,
    output logic              fatal_o,
    output logic [7:0]        status_o
);
    import chunk_seq_pkg::*;

    localparam int SEC_BYTES_W = NSEC_W + SECT_SHIFT;
    localparam int W_A   = (SEC_BYTES_W > PKT_W) ? SEC_BYTES_W : PKT_W;
    localparam int W_B   = (W_A > LEN_W) ? W_A : LEN_W;
    localparam int REM_W = W_B + 1;

    typedef struct packed {
        seq_state_e        st;
        logic              active;
        logic [REM_W-1:0]  rem;
        logic [OFF_W-1:0]  idx;
        logic              optical;
        logic [1:0]        cmd;
        logic [LBA_W-1:0]  base;
        logic              nolba;
        logic              copying;
        logic              req;
        sto_op_e           op;
        logic [OFF_W-1:0]  off;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              fin;
        logic              ok;
        logic              irq;
        logic              err;
        logic              fatal;
        logic              parked;
        logic [7:0]        status;
    } ctrl_t;

    ctrl_t d, q;

    logic [REM_W-1:0] rem_load;
    logic [REM_W-1:0] len_ext;
    logic             rem_pos;
    logic             len_below_rem;

    always_comb begin
        rem_load = optical_i ? REM_W'(pkt_bytes_i)
                             : REM_W'({nsect_i, {SECT_SHIFT{1'b0}}});
        len_ext       = REM_W'(chunk_len_i);
        rem_pos       = $signed(q.rem) > $signed(REM_W'(0));
        len_below_rem = $signed(len_ext) < $signed(q.rem);
    end

    always_comb begin
        d        = q;
        d.req    = 1'b0;
        d.fin    = 1'b0;
        d.ok     = 1'b0;
        d.irq    = 1'b0;
        d.err    = 1'b0;
        d.parked = 1'b0;

        unique case (q.st)
            ST_IDLE, ST_END: begin
                if (q.st == ST_END) begin
                    d.st = ST_IDLE;
                end
                if (start_i) begin
                    d.st      = ST_IDLE;
                    d.active  = 1'b1;
                    d.rem     = rem_load;
                    d.idx     = '0;
                    d.optical = optical_i;
                    d.cmd     = cmd_i;
                    d.base    = optical_i ? lba_i : sector_i;
                    d.nolba   = optical_i && (&lba_i);
                    d.fatal   = 1'b0;
                    d.status  = STAT_BUSY;
                end else if (q.st == ST_IDLE && chunk_valid_i) begin
                    if (!q.active) begin
                        d.parked = 1'b1;
                    end else if (!rem_pos) begin
                        d.st     = ST_END;
                        d.fin    = 1'b1;
                        d.active = 1'b0;
                        d.status = STAT_DONE;
                        d.ok     = q.optical;
                        d.irq    = !q.optical;
                    end else if (chunk_len_i == '0) begin
                        d.st  = ST_END;
                        d.fin = 1'b1;
                    end else if (q.nolba) begin
                        d.st      = ST_BUSY;
                        d.req     = 1'b1;
                        d.copying = 1'b1;
                        d.op      = OP_COPY;
                        d.off     = '0;
                        d.addr    = chunk_addr_i;
                        d.len     = len_below_rem ? chunk_len_i : LEN_W'(q.rem);
                    end else if (!q.optical && q.cmd == CMD_BAD) begin
                        d.st     = ST_END;
                        d.fin    = 1'b1;
                        d.fatal  = 1'b1;
                        d.active = 1'b0;
                    end else begin
                        d.st      = ST_BUSY;
                        d.req     = 1'b1;
                        d.copying = 1'b0;
                        d.op      = q.optical ? OP_READ : sto_op_e'(q.cmd);
                        d.off     = off_i;
                        d.addr    = chunk_addr_i;
                        d.len     = chunk_len_i;
                        d.rem     = q.rem - len_ext;
                        d.idx     = q.idx + OFF_W'(chunk_len_i);
                    end
                end
            end
            ST_BUSY: begin
                if (sto_done_i) begin
                    d.st  = ST_END;
                    d.fin = 1'b1;
                    if (sto_err_i) begin
                        d.err    = 1'b1;
                        d.active = 1'b0;
                        d.status = STAT_FAIL;
                    end else if (q.copying) begin
                        d.ok     = 1'b1;
                        d.active = 1'b0;
                        d.status = STAT_DONE;
                    end else if (!rem_pos) begin
                        d.active = 1'b0;
                        d.status = STAT_DONE;
                        d.ok     = q.optical;
                        d.irq    = !q.optical;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign optical_o  = q.optical;
    assign base_o     = q.base;
    assign idx_o      = q.idx;
    assign busy_o     = (q.st == ST_BUSY);
    assign sto_req_o  = q.req;
    assign sto_op_o   = q.op;
    assign sto_off_o  = q.off;
    assign sto_addr_o = q.addr;
    assign sto_len_o  = q.len;
    assign dma_end_o  = q.fin;
    assign active_o   = q.active;
    assign parked_o   = q.parked;
    assign cmd_ok_o   = q.ok;
    assign disk_irq_o = q.irq;
    assign io_err_o   = q.err;
    assign fatal_o    = q.fatal;
    assign status_o   = q.status;

    p_park_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        parked_o |-> !sto_req_o && !dma_end_o && !active_o);

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok_o || disk_irq_o) |-> dma_end_o && !active_o && status_o == STAT_DONE);

    p_fatal_noreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fatal_o) |-> dma_end_o && !sto_req_o);

    p_err_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        io_err_o |-> dma_end_o && !active_o && status_o == STAT_FAIL);

    p_copy_zero_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sto_req_o && sto_op_o == OP_COPY) |-> sto_off_o == '0);

    p_req_waits_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sto_req_o |=> !dma_end_o);

    p_end_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_end_o && $past(busy_o)) |-> $past(sto_done_i));

    p_end_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_end_o |=> !dma_end_o);

endmodule

// File: rtl/dma_chunk_seq.sv
module dma_chunk_seq #(
    parameter int LBA_W  = 24,
    parameter int NSEC_W = 8,
    parameter int PKT_W  = 16,
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                optical_i,
    input  logic [1:0]          cmd_i,
    input  logic [LBA_W-1:0]    sector_i,
    input  logic [NSEC_W-1:0]   nsect_i,
    input  logic [PKT_W-1:0]    pkt_bytes_i,
    input  logic [LBA_W-1:0]    lba_i,
    input  logic                chunk_valid_i,
    input  logic [ADDR_W-1:0]   chunk_addr_i,
    input  logic [LEN_W-1:0]    chunk_len_i,
    input  logic                sto_done_i,
    input  logic                sto_err_i,
    input  logic                flush_i,
    output logic                sto_req_o,
    output logic [1:0]          sto_op_o,
    output logic [LBA_W+11:0]   sto_off_o,
    output logic [ADDR_W-1:0]   sto_addr_o,
    output logic [LEN_W-1:0]    sto_len_o,
    output logic                dma_end_o,
    output logic                active_o,
    output logic                parked_o,
    output logic                cmd_ok_o,
    output logic                disk_irq_o,
    output logic                io_err_o,
    output logic                fatal_o,
    output logic [7:0]          status_o,
    output logic                flush_ack_o
);

    localparam int OFF_W = LBA_W + 12;

    logic             cur_optical;
    logic [LBA_W-1:0] cur_base;
    logic [OFF_W-1:0] cur_idx;
    logic [OFF_W-1:0] cur_off;
    logic             busy;

    chunk_seq_offset #(
        .LBA_W (LBA_W),
        .OFF_W (OFF_W)
    ) i_offset (
        .optical_i (cur_optical),
        .base_i    (cur_base),
        .idx_i     (cur_idx),
        .off_o     (cur_off)
    );

    chunk_seq_ctrl #(
        .LBA_W  (LBA_W),
        .NSEC_W (NSEC_W),
        .PKT_W  (PKT_W),
        .LEN_W  (LEN_W),
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .optical_i     (optical_i),
        .cmd_i         (cmd_i),
        .sector_i      (sector_i),
        .nsect_i       (nsect_i),
        .pkt_bytes_i   (pkt_bytes_i),
        .lba_i         (lba_i),
        .chunk_valid_i (chunk_valid_i),
        .chunk_addr_i  (chunk_addr_i),
        .chunk_len_i   (chunk_len_i),
        .sto_done_i    (sto_done_i),
        .sto_err_i     (sto_err_i),
        .off_i         (cur_off),
        .optical_o     (cur_optical),
        .base_o        (cur_base),
        .idx_o         (cur_idx),
        .busy_o        (busy),
        .sto_req_o     (sto_req_o),
        .sto_op_o      (sto_op_o),
        .sto_off_o     (sto_off_o),
        .sto_addr_o    (sto_addr_o),
        .sto_len_o     (sto_len_o),
        .dma_end_o     (dma_end_o),
        .active_o      (active_o),
        .parked_o      (parked_o),
        .cmd_ok_o      (cmd_ok_o),
        .disk_irq_o    (disk_irq_o),
        .io_err_o      (io_err_o),
        .fatal_o       (fatal_o),
        .status_o      (status_o)
    );

    chunk_seq_flush i_flush (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .busy_i      (busy),
        .flush_ack_o (flush_ack_o)
    );

endmodule

// File: tb/test_dma_chunk_seq.sv
module test_dma_chunk_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        optical_i = 1'b0;
    logic [1:0]  cmd_i = '0;
    logic [23:0] sector_i = '0;
    logic [7:0]  nsect_i = '0;
    logic [15:0] pkt_bytes_i = '0;
    logic [23:0] lba_i = '0;
    logic        chunk_valid_i = 1'b0;
    logic [31:0] chunk_addr_i = '0;
    logic [15:0] chunk_len_i = '0;
    logic        sto_done_i = 1'b0;
    logic        sto_err_i = 1'b0;
    logic        flush_i = 1'b0;
    logic        sto_req_o;
    logic [1:0]  sto_op_o;
    logic [35:0] sto_off_o;
    logic [31:0] sto_addr_o;
    logic [15:0] sto_len_o;
    logic        dma_end_o, active_o, parked_o, cmd_ok_o, disk_irq_o;
    logic        io_err_o, fatal_o, flush_ack_o;
    logic [7:0]  status_o;

    dma_chunk_seq i_dma_chunk_seq (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // bench model of the transfer
    bit          m_opt, m_nolba, m_active, m_fatal;
    logic [1:0]  m_cmd;
    longint      m_base, m_rem, m_idx;
    logic [7:0]  m_status;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint exp_off(input longint idx);
        longint o;
        o = (m_opt ? (m_base << 11) : (m_base << 9)) + idx;
        return o & 64'hF_FFFF_FFFF;
    endfunction

    task automatic do_start(input bit opt, input logic [1:0] cmd, input logic [23:0] sec,
                            input logic [7:0] ns, input logic [15:0] pkt, input logic [23:0] lba);
        optical_i = opt; cmd_i = cmd; sector_i = sec; nsect_i = ns;
        pkt_bytes_i = pkt; lba_i = lba; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        m_opt = opt; m_cmd = cmd; m_base = opt ? longint'(lba) : longint'(sec);
        m_nolba = opt && (lba == 24'hFF_FFFF);
        m_rem = opt ? longint'(pkt) : longint'(ns) * 512;
        m_idx = 0; m_active = 1'b1; m_fatal = 1'b0; m_status = 8'h80;
        chk("R1 active after start", active_o, 1);
        chk("R1 status after start", status_o, 8'h80);
        chk("R8 fatal cleared by start", fatal_o, 0);
    endtask

    task automatic chunk(input logic [31:0] a, input logic [15:0] l, input bit err);
        bit e_req = 0, e_ok = 0, e_irq = 0, e_err = 0;
        logic [1:0] e_op = 0;
        longint e_off = 0, e_len = 0;
        bit s_req = 0, s_ok = 0, s_irq = 0, s_err = 0, s_end = 0, s_ack_done = 0;
        logic [1:0] g_op = 0;
        longint g_off = 0, g_len = 0, g_addr = 0;
        int countdown = -1;
        if (!m_active) begin
            $display("bench misuse");
        end else if (m_rem <= 0) begin
            e_ok = m_opt; e_irq = !m_opt; m_status = 8'h50; m_active = 0;
        end else if (l == 0) begin
        end else if (m_nolba) begin
            e_req = 1; e_op = 3; e_off = 0; e_len = (l < m_rem) ? l : m_rem;
            if (err) begin e_err = 1; m_status = 8'h51; end
            else begin e_ok = 1; m_status = 8'h50; end
            m_active = 0;
        end else if (!m_opt && m_cmd == 2'd3) begin
            m_fatal = 1; m_active = 0;
        end else begin
            e_req = 1; e_op = m_opt ? 2'd0 : m_cmd; e_off = exp_off(m_idx); e_len = l;
            m_rem -= l; m_idx += l;
            if (err) begin e_err = 1; m_status = 8'h51; m_active = 0; end
            else if (m_rem <= 0) begin
                e_ok = m_opt; e_irq = !m_opt; m_status = 8'h50; m_active = 0;
            end
        end
        chunk_valid_i = 1'b1; chunk_addr_i = a; chunk_len_i = l;
        for (int i = 0; i < 60 && !s_end; i++) begin
            @(negedge clk);
            if (sto_done_i) begin sto_done_i = 1'b0; sto_err_i = 1'b0; s_ack_done = 1; end
            if (sto_req_o) begin
                s_req = 1; g_op = sto_op_o; g_off = sto_off_o; g_len = sto_len_o; g_addr = sto_addr_o;
                countdown = 2;
            end
            if (cmd_ok_o) s_ok = 1;
            if (disk_irq_o) s_irq = 1;
            if (io_err_o) s_err = 1;
            if (dma_end_o) begin
                s_end = 1;
                if (s_req) chk("R11 end only after storage done", s_ack_done, 1);
            end else if (countdown == 0) begin
                sto_done_i = 1'b1; sto_err_i = err; countdown = -1;
            end else if (countdown > 0) begin
                countdown--;
            end
        end
        chunk_valid_i = 1'b0;
        chk("R11 step end strobe", s_end, 1);
        chk("R6 request issued", s_req, e_req);
        if (e_req && s_req) begin
            chk("R7 op code", g_op, e_op);
            chk(e_op == 3 ? "R10 copy offset" : "R5 storage offset", g_off, e_off);
            chk(e_op == 3 ? "R10 copy length" : "R6 request length", g_len, e_len);
            chk("R6 request address", g_addr, a);
        end
        chk("R3 command-done pulse", s_ok, e_ok);
        chk("R3 disk interrupt pulse", s_irq, e_irq);
        chk("R9 error pulse", s_err, e_err);
        chk("R3 active level", active_o, m_active);
        chk("R3 status byte", status_o, m_status);
        chk("R8 fatal flag", fatal_o, m_fatal);
        @(negedge clk);
        chk("R11 single strobe", dma_end_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset active", active_o, 0);
        chk("R3 reset status", status_o, 0);
        chk("R11 reset strobe", dma_end_o, 0);
        chk("R6 reset request", sto_req_o, 0);

        // disk read with a zero-length chunk in the middle
        do_start(0, 2'd0, 24'h10, 8'd2, 16'd0, 24'd0);
        chunk(32'h1000, 16'd300, 0);
        chunk(32'h2000, 16'd0, 0);   // R4
        chk("R4 index kept", m_idx, 300);
        chunk(32'h3000, 16'd724, 0);

        // parked chunk, then armed optical transfer
        chunk_valid_i = 1'b1; chunk_addr_i = 32'h4000; chunk_len_i = 16'd1000;
        repeat (3) @(negedge clk);
        chk("R2 parked flag", parked_o, 1);
        chk("R2 no request while parked", sto_req_o, 0);
        chk("R2 no strobe while parked", dma_end_o, 0);
        do_start(1, 2'd1, 24'd0, 8'd0, 16'd2048, 24'd5);
        chunk(32'h4000, 16'd1000, 0);
        chunk(32'h5000, 16'd1048, 0);

        // optical overshoot
        do_start(1, 2'd0, 24'd0, 8'd0, 16'd100, 24'h123);
        chunk(32'h6000, 16'd300, 0);

        // buffer copy, chunk larger and smaller than the count
        do_start(1, 2'd0, 24'd0, 8'd0, 16'd50, 24'hFF_FFFF);
        chunk(32'h7000, 16'd200, 0);
        do_start(1, 2'd0, 24'd0, 8'd0, 16'd500, 24'hFF_FFFF);
        chunk(32'h7100, 16'd64, 0);

        // illegal disk command
        do_start(0, 2'd3, 24'd7, 8'd1, 16'd0, 24'd0);
        chunk(32'h8000, 16'd512, 0);

        // storage error on a disk write
        do_start(0, 2'd1, 24'd9, 8'd4, 16'd0, 24'd0);
        chunk(32'h9000, 16'd512, 1);

        // trim, then completion from an empty count
        do_start(0, 2'd2, 24'd33, 8'd1, 16'd0, 24'd0);
        chunk(32'hA000, 16'd512, 0);
        do_start(0, 2'd0, 24'd1, 8'd0, 16'd0, 24'd0);
        chunk(32'hB000, 16'd100, 0);

        // flush while idle
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        chk("R12 idle flush acknowledged next cycle", flush_ack_o, 1);
        @(negedge clk);
        chk("R12 acknowledge is one cycle", flush_ack_o, 0);

        // flush and ignored start while a storage operation is outstanding
        do_start(0, 2'd0, 24'h40, 8'd1, 16'd0, 24'd0);
        chunk_valid_i = 1'b1; chunk_addr_i = 32'hC000; chunk_len_i = 16'd512;
        @(negedge clk);
        @(negedge clk);
        chk("R5 flush case offset", sto_off_o, longint'(24'h40) << 9);
        flush_i = 1'b1; start_i = 1'b1; nsect_i = 8'd9;
        @(negedge clk);
        flush_i = 1'b0; start_i = 1'b0;
        begin
            bit early = 0, ack = 0, fin = 0, irq = 0;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (flush_ack_o) early = 1;
            end
            chk("R12 no acknowledge while busy", early, 0);
            sto_done_i = 1'b1;
            @(negedge clk);
            sto_done_i = 1'b0;
            for (int i = 0; i < 6; i++) begin
                if (flush_ack_o) ack = 1;
                if (dma_end_o) begin fin = 1; chunk_valid_i = 1'b0; end
                if (disk_irq_o) irq = 1;
                @(negedge clk);
            end
            chk("R12 acknowledge after storage done", ack, 1);
            chk("R11 strobe after storage done", fin, 1);
            chk("R1 start ignored while busy", irq, 1);
            chk("R1 start ignored, active cleared", active_o, 0);
        end
        m_active = 0; m_status = 8'h50;

        // random transfers
        for (int t = 0; t < 40; t++) begin
            bit opt;
            logic [1:0] cmd;
            opt = $urandom_range(0, 1);
            cmd = 2'($urandom_range(0, 2));
            do_start(opt, cmd, 24'($urandom) & 24'h7F_FFFF, 8'($urandom_range(0, 4)),
                     16'($urandom_range(0, 3000)), 24'($urandom) & 24'h7F_FFFF);
            for (int c = 0; c < 12 && m_active; c++) begin
                logic [15:0] l;
                l = ($urandom_range(0, 7) == 0) ? 16'd0 : 16'($urandom_range(1, 1400));
                chunk($urandom, l, $urandom_range(0, 14) == 0);
            end
        end

        finished = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule